// File: doc/BRIEF.md
# Privileged Status and Cause Control Registers

This block keeps the processor's privileged Status and Cause words. Software updates them through a write port made of a shared 32-bit data bus and one write strobe per register. A two-bit revision input selects which write rules apply. A write is not a plain masked store. Depending on the revision, some bits can only be cleared, some encodings are refused, and the three segment-enable bits constrain one another.

Both registers are visible on their outputs at all times. The block also drives the control lines that depend on their fields:
- a count-enable level for the cycle counter, which is low while the counter is halted by software;
- two software interrupt request lines;
- a single-cycle request to flush address translation, raised when access to a segment is withdrawn.

Top module: `sscr_top`

## Requirements
- R1: While reset is asserted, Status reads 0x00400004 (bit 22 boot-vector select and bit 2 error level set). When the revision input reads R6 and the `FPU_64` parameter is 1, bit 26 (float register mode) is also set, giving 0x04400004. Cause reads 0, count-enable is 1, both software interrupt lines are 0 and the flush request is 0.
- R2: A Status write changes only bits set in the `STATUS_RW_MASK` parameter. Those bits take the write data, unless a rule below overrides it. All other bits keep their value. The new word appears on `statusOut` after the clock edge that samples the write.
- R3: A Cause write changes only bits 8, 9, 22 and 23. It also changes bit 27 (counter halt) when the revision is R2 or later. The revision encoding is 0 = legacy, 1 = R2, and 2 or 3 = R6.
- R4: Under R6, Cause bit 22 (watch pending) can only be cleared. Writing 1 leaves it unchanged and writing 0 clears it. Under the other revisions it is an ordinary writable bit.
- R5: `countEn` equals the inverse of Cause bit 27. It changes at the same edge as the Cause write that flips that bit.
- R6: `softIrq[i]` equals Cause bit 8+i. It changes at the same edge as the Cause write that flips that bit.
- R7: Under R6, the write data's segment bits are chained before the mask is applied. Bit 7 (kernel) at 0 forces bit 6 (supervisor) to 0, and bit 6 at 0 forces bit 5 (user) to 0.
- R8: Under R6, when both mode bits 4:3 are in `STATUS_RW_MASK`, a write carrying 2'b11 in bits 4:3 leaves them unchanged. Under the other revisions, 2'b11 is stored.
- R9: Under R6, Status bits 20 (soft reset) and 19 (NMI) can only be cleared. Writing 1 to them has no effect. Under the other revisions they follow R2.
- R10: `flushReq` is high for exactly the one cycle after the edge of a Status write that clears at least one of bits 5, 6 and 7 that was set. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| revLevel | input | 2 | Revision selector: 0 legacy, 1 R2, 2 or 3 R6 |
| wrData | input | 32 | Write data shared by both registers |
| statusWr | input | 1 | Write strobe for Status |
| causeWr | input | 1 | Write strobe for Cause |
| statusOut | output | 32 | Current Status word |
| causeOut | output | 32 | Current Cause word |
| countEn | output | 1 | High while the cycle counter may run |
| softIrq | output | 2 | Software interrupt request lines |
| flushReq | output | 1 | One-cycle translation flush request |

## Verification
A wrong rule in the next-value logic shows up on `statusOut` or `causeOut` one edge after the offending write. The bench compares both words after every write, so such a fault is reported within one cycle. A side-effect register that drifts from its source bit differs from the matching Cause bit, or from the cleared segment bits, in the same cycle. A flush pulse that is lost or stretched is caught on the cycle of the write or on the idle cycle that follows. Corner encodings are checked directly: mode 2'b11, clear-only bits written with 1, a break in the segment chain, and the counter-halt bit under the legacy revision.

// File: rtl/sscr_pkg.sv
package sscr_pkg;
  localparam int REG_W      = 32;
  localparam int SOFT_IRQS  = 2;
  // Status field positions
  localparam int ST_ERL     = 2;
  localparam int ST_MODE_LO = 3;
  localparam int ST_UX      = 5;
  localparam int ST_SX      = 6;
  localparam int ST_KX      = 7;
  localparam int ST_NMI     = 19;
  localparam int ST_SR      = 20;
  localparam int ST_BEV     = 22;
  localparam int ST_FR      = 26;
  // Cause field positions
  localparam int CA_IP_LO   = 8;
  localparam int CA_WP      = 22;
  localparam int CA_DC      = 27;
  localparam logic [REG_W-1:0] CA_BASE_MASK = 32'h00C0_0300;
  localparam logic [REG_W-1:0] SEG_MASK     = 32'h0000_00E0;
  localparam logic [REG_W-1:0] ST_RESET     = (32'd1 << ST_BEV) | (32'd1 << ST_ERL);

  typedef struct packed {
    logic stWr;
    logic caWr;
    logic isR2up;
    logic isR6;
  } wr_strobe_t;
endpackage

// File: rtl/sscr_ctrl.sv
module sscr_ctrl
  import sscr_pkg::*;
(
  input  logic [1:0]  revLevel,
  input  logic        statusWr,
  input  logic        causeWr,
  output wr_strobe_t  strobe
);
  always_comb begin
    strobe.stWr   = statusWr;
    strobe.caWr   = causeWr;
    strobe.isR2up = (revLevel != 2'd0);
    strobe.isR6   = revLevel[1];
  end
endmodule

// File: rtl/sscr_datapath.sv
module sscr_datapath
  import sscr_pkg::*;
#(
  parameter logic [REG_W-1:0] STATUS_RW_MASK = 32'h3C78_00FF,
  parameter bit               FPU_64         = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  wr_strobe_t       strobe,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] statusQ,
  output logic [REG_W-1:0] causeQ,
  output logic [REG_W-1:0] statusNext,
  output logic [REG_W-1:0] causeNext
);
  localparam bit HAS_SUPER = STATUS_RW_MASK[ST_MODE_LO] & STATUS_RW_MASK[ST_MODE_LO+1];
  localparam bit SEG_ALL_RW = STATUS_RW_MASK[ST_UX] & STATUS_RW_MASK[ST_SX] & STATUS_RW_MASK[ST_KX];

  logic [REG_W-1:0] stVal, stMask, caMask, resetVal;
  logic kxBit, sxBit, uxBit;

  // Status next-value rules
  always_comb begin
    stVal  = wrData;
    stMask = STATUS_RW_MASK;
    kxBit  = wrData[ST_KX];
    sxBit  = wrData[ST_SX] & kxBit;
    uxBit  = wrData[ST_UX] & sxBit;
    if (strobe.isR6) begin
      stVal[ST_KX] = kxBit;
      stVal[ST_SX] = sxBit;
      stVal[ST_UX] = uxBit;
      if (HAS_SUPER && (wrData[ST_MODE_LO+1:ST_MODE_LO] == 2'b11))
        stMask[ST_MODE_LO+1:ST_MODE_LO] = 2'b00;
      stMask[ST_SR]  = stMask[ST_SR]  & ~wrData[ST_SR];
      stMask[ST_NMI] = stMask[ST_NMI] & ~wrData[ST_NMI];
    end
    statusNext = strobe.stWr ? ((statusQ & ~stMask) | (stVal & stMask)) : statusQ;
  end

  // Cause next-value rules
  always_comb begin
    caMask = CA_BASE_MASK;
    if (strobe.isR2up) caMask[CA_DC] = 1'b1;
    if (strobe.isR6 && wrData[CA_WP]) caMask[CA_WP] = 1'b0;
    causeNext = strobe.caWr ? ((causeQ & ~caMask) | (wrData & caMask)) : causeQ;
  end

  always_comb begin
    resetVal = ST_RESET;
    if (FPU_64 && strobe.isR6) resetVal[ST_FR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= resetVal;
      causeQ  <= '0;
    end else begin
      statusQ <= statusNext;
      causeQ  <= causeNext;
    end
  end

  // R2: bits outside the writable mask never move
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ ^ $past(statusQ)) & ~STATUS_RW_MASK) == '0);

  // R3: counter-halt bit is frozen under the legacy revision
  assert_dc_legacy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.caWr && !strobe.isR2up) |=> $stable(causeQ[CA_DC]));

  // R4: watch pending never rises from an R6 write
  assert_wp_clear_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.caWr && strobe.isR6) |=> !$rose(causeQ[CA_WP]));

  // R7: segment chain holds after an R6 write
  assert_seg_chain_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stWr && strobe.isR6 && SEG_ALL_RW) |=>
      !((statusQ[ST_SX] && !statusQ[ST_KX]) || (statusQ[ST_UX] && !statusQ[ST_SX])));

  // R8: mode 2'b11 is refused under R6
  assert_mode_reject_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stWr && strobe.isR6 && HAS_SUPER &&
     wrData[ST_MODE_LO+1:ST_MODE_LO] == 2'b11) |=> $stable(statusQ[ST_MODE_LO+1:ST_MODE_LO]));

  // R9: soft reset and NMI flags never rise from an R6 write
  assert_sr_nmi_clear_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stWr && strobe.isR6) |=> (!$rose(statusQ[ST_SR]) && !$rose(statusQ[ST_NMI])));
endmodule

// File: rtl/sscr_events.sv
module sscr_events
  import sscr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  wr_strobe_t           strobe,
  input  logic [REG_W-1:0]     statusQ,
  input  logic [REG_W-1:0]     causeQ,
  input  logic [REG_W-1:0]     statusNext,
  input  logic [REG_W-1:0]     causeNext,
  output logic                 countEn,
  output logic [SOFT_IRQS-1:0] softIrq,
  output logic                 flushReq
);
  logic segDropped;
  assign segDropped = |(statusQ & ~statusNext & SEG_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countEn  <= 1'b1;
      flushReq <= 1'b0;
    end else begin
      if (strobe.caWr && (causeNext[CA_DC] != causeQ[CA_DC]))
        countEn <= ~causeNext[CA_DC];
      flushReq <= strobe.stWr && segDropped;
    end
  end

  for (genvar i = 0; i < SOFT_IRQS; i++) begin : gSoft
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) softIrq[i] <= 1'b0;
      else if (strobe.caWr && (causeNext[CA_IP_LO+i] != causeQ[CA_IP_LO+i]))
        softIrq[i] <= causeNext[CA_IP_LO+i];
    end
  end

  // R5: count enable tracks the halt bit
  assert_count_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    countEn == ~causeQ[CA_DC]);

  // R6: soft interrupt lines track their pending bits
  assert_soft_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    softIrq == causeQ[CA_IP_LO +: SOFT_IRQS]);

  // R10: a flush pulse only follows a status write that dropped a segment bit
  assert_flush_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> ($past(strobe.stWr) && |($past(statusQ) & ~statusQ & SEG_MASK)));
endmodule

// File: rtl/sscr_top.sv
module sscr_top
  import sscr_pkg::*;
#(
  parameter logic [31:0] STATUS_RW_MASK = 32'h3C78_00FF,
  parameter bit          FPU_64         = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  revLevel,
  input  logic [31:0] wrData,
  input  logic        statusWr,
  input  logic        causeWr,
  output logic [31:0] statusOut,
  output logic [31:0] causeOut,
  output logic        countEn,
  output logic [1:0]  softIrq,
  output logic        flushReq
);
  wr_strobe_t       strobe;
  logic [REG_W-1:0] statusNext, causeNext;

  sscr_ctrl uCtrl (
    .revLevel (revLevel),
    .statusWr (statusWr),
    .causeWr  (causeWr),
    .strobe   (strobe)
  );

  sscr_datapath #(
    .STATUS_RW_MASK (STATUS_RW_MASK),
    .FPU_64         (FPU_64)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .statusQ    (statusOut),
    .causeQ     (causeOut),
    .statusNext (statusNext),
    .causeNext  (causeNext)
  );

  sscr_events uEvt (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .statusQ    (statusOut),
    .causeQ     (causeOut),
    .statusNext (statusNext),
    .causeNext  (causeNext),
    .countEn    (countEn),
    .softIrq    (softIrq),
    .flushReq   (flushReq)
  );
endmodule

// File: tb/sscr_top_test.sv
module sscr_top_test;
  localparam logic [31:0] RW = 32'h3C78_00FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] revLevel = 2'd0;
  logic [31:0] wrData = '0;
  logic statusWr = 1'b0, causeWr = 1'b0;
  logic [31:0] statusOut, causeOut;
  logic countEn, flushReq;
  logic [1:0] softIrq;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;
  logic [31:0] mSt, mCa;
  logic mFlush;

  always #5 clk = ~clk;

  sscr_top #(.STATUS_RW_MASK(RW), .FPU_64(1'b1)) uut (
    .clk(clk), .rstN(rstN), .revLevel(revLevel), .wrData(wrData),
    .statusWr(statusWr), .causeWr(causeWr), .statusOut(statusOut),
    .causeOut(causeOut), .countEn(countEn), .softIrq(softIrq), .flushReq(flushReq)
  );

  function automatic logic [31:0] modelStatus(logic [31:0] old, logic [31:0] v, logic [1:0] rev);
    logic [31:0] m = RW;
    if (rev >= 2) begin
      if (!v[7]) v[6] = 1'b0;
      if (!v[6]) v[5] = 1'b0;
      if (v[4:3] == 2'b11) m[4:3] = 2'b00;
      if (v[20]) m[20] = 1'b0;
      if (v[19]) m[19] = 1'b0;
    end
    return (old & ~m) | (v & m);
  endfunction

  function automatic logic [31:0] modelCause(logic [31:0] old, logic [31:0] v, logic [1:0] rev);
    logic [31:0] m = 32'h00C0_0300;
    if (rev != 0) m[27] = 1'b1;
    if (rev >= 2 && v[22]) m[22] = 1'b0;
    return (old & ~m) | (v & m);
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string ctx);
    check32({ctx, " status R2"}, statusOut, mSt);
    check32({ctx, " cause R3"}, causeOut, mCa);
    check32({ctx, " countEn R5"}, {31'd0, countEn}, {31'd0, ~mCa[27]});
    check32({ctx, " softIrq R6"}, {30'd0, softIrq}, {30'd0, mCa[9:8]});
    check32({ctx, " flush R10"}, {31'd0, flushReq}, {31'd0, mFlush});
  endtask

  // one write (or idle) cycle; results sampled at the next falling edge
  task automatic cyc(bit st, bit ca, logic [31:0] d, logic [1:0] rev);
    logic [31:0] nSt;
    revLevel = rev; wrData = d; statusWr = st; causeWr = ca;
    nSt = st ? modelStatus(mSt, d, rev) : mSt;
    mFlush = st && (|(mSt & ~nSt & 32'hE0));
    mSt = nSt;
    if (ca) mCa = modelCause(mCa, d, rev);
    @(negedge clk);
    statusWr = 1'b0; causeWr = 1'b0;
  endtask

  task automatic doReset(logic [1:0] rev);
    rstN = 1'b0; revLevel = rev;
    repeat (2) @(negedge clk);
    check32("reset status R1", statusOut, rev >= 2 ? 32'h0440_0004 : 32'h0040_0004);
    check32("reset cause R1", causeOut, 32'h0);
    check32("reset countEn R1", {31'd0, countEn}, 32'd1);
    check32("reset softIrq R1", {30'd0, softIrq}, 32'd0);
    check32("reset flush R1", {31'd0, flushReq}, 32'd0);
    mSt = statusOut; mCa = 32'h0; mFlush = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset(2'd0);
    doReset(2'd2);

    // R2: write all ones under legacy
    cyc(1, 0, 32'hFFFF_FFFF, 2'd0);
    check32("mask R2", statusOut, 32'h0440_0004 | RW);
    // R9: clear soft reset / NMI under R6, then a 1 must not set them
    cyc(1, 0, 32'h0000_00E0, 2'd2);
    check32("sr nmi clear R9", statusOut & 32'h0018_0000, 32'h0);
    cyc(1, 0, 32'h0018_00E0, 2'd2);
    check32("sr nmi stay R9", statusOut & 32'h0018_0000, 32'h0);
    checkAll("dir");
    // R10: dropping all segment bits raises one pulse
    cyc(1, 0, 32'h0000_0000, 2'd2);
    check32("flush high R10", {31'd0, flushReq}, 32'd1);
    cyc(0, 0, 32'h0, 2'd2);
    check32("flush low R10", {31'd0, flushReq}, 32'd0);
    // R7: broken chain
    cyc(1, 0, 32'h0000_0060, 2'd2);
    check32("chain kx0 R7", statusOut & 32'hE0, 32'h0);
    cyc(1, 0, 32'h0000_00A0, 2'd2);
    check32("chain sx0 R7", statusOut & 32'hE0, 32'h80);
    // R8: mode 11 refused in R6, accepted in legacy
    cyc(1, 0, 32'h0000_0008, 2'd2);
    cyc(1, 0, 32'h0000_0018, 2'd2);
    check32("mode reject R8", statusOut & 32'h18, 32'h08);
    cyc(1, 0, 32'h0000_0018, 2'd0);
    check32("mode legacy R8", statusOut & 32'h18, 32'h18);
    // R3: halt bit ignored under legacy, taken under R2
    cyc(0, 1, 32'hFFFF_FFFF, 2'd0);
    check32("cause legacy R3", causeOut, 32'h00C0_0300);
    check32("countEn legacy R5", {31'd0, countEn}, 32'd1);
    check32("softIrq set R6", {30'd0, softIrq}, 32'd3);
    cyc(0, 1, 32'h0800_0000, 2'd1);
    check32("halt set R3", causeOut, 32'h0800_0000);
    check32("countEn low R5", {31'd0, countEn}, 32'd0);
    check32("softIrq clr R6", {30'd0, softIrq}, 32'd0);
    // R4: watch pending clear only under R6
    cyc(0, 1, 32'h0040_0000, 2'd0);
    cyc(0, 1, 32'h0040_0000, 2'd2);
    check32("wp keep R4", causeOut & 32'h0040_0000, 32'h0040_0000);
    cyc(0, 1, 32'h0000_0000, 2'd2);
    check32("wp clear R4", causeOut & 32'h0040_0000, 32'h0);
    cyc(0, 1, 32'h0040_0000, 2'd2);
    check32("wp no set R4", causeOut & 32'h0040_0000, 32'h0);
    checkAll("dir");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] d = $urandom();
      if ($urandom_range(3) == 0) d[7:3] = 5'b11111;
      cyc($urandom_range(1) == 1, $urandom_range(1) == 1, d, 2'($urandom_range(3)));
      checkAll("rnd");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule